// File: doc/BRIEF.md
# E1 Automatic Transmit Alarm Controller

This block sits between the receive-side alarm detectors of an E1 port and its transmit framer. It watches three receive fault flags (frame alignment lost, all-ones alarm received, signal lost) and the CRC-4 multiframe alignment status. It then decides, once per transmit frame, whether the transmit side must send an alarm. Two enable inputs select the response. In all-ones mode a fault forces the outgoing data to all ones. In remote-alarm mode a fault raises the remote alarm bit that the framer places in its non-alignment timeslot 0 word.

In remote-alarm mode a search timer also runs. It counts millisecond ticks while the receiver is frame aligned but has no multiframe alignment. If the count reaches `TIMEOUT_TICKS` (default 400, that is 400 ms), a constant remote alarm is sent until multiframe alignment is found. Setting both enables at once is illegal: the block raises a flag and sends no alarm.

The design has two state machines.

The search timer uses four states:
- `TS_IDLE`: frame alignment is lost.
- `TS_HUNT`: aligned, counting ticks.
- `TS_EXPIRED`: the count has run out.
- `TS_LOCKED`: multiframe alignment is held.

Its transitions are:
- IDLE→LOCKED: frame alignment is present and multiframe alignment is present.
- IDLE→HUNT: frame alignment is present and multiframe alignment is absent.
- HUNT→EXPIRED: on the tick that completes the count.
- HUNT, EXPIRED→LOCKED: multiframe alignment is found.
- LOCKED→HUNT: multiframe alignment is lost.
- Any state→IDLE: frame alignment is lost.

The output machine uses three states: `OS_QUIET`, `OS_SEND_AIS` and `OS_SEND_RAI`. It moves only on a frame-boundary strobe. At each strobe it goes to the state chosen by the mode, the fault trigger and the timer result. It may go from any state to any other.

Top module: `e1_tx_alarm_ctrl`

## Requirements
- R1: With neither enable set, no fault causes any alarm output.
- R2: With both enables set, `o_illegal_cfg` is 1 from the cycle after the setting, and both alarm outputs are 0 after the next frame strobe. The flag drops one cycle after the setting is removed.
- R3: The fault trigger is the OR of `i_frame_sync_lost`, `i_ais_rx` and `i_sig_lost`.
- R4: With only `i_en_ais` set, a trigger present at a frame strobe drives `o_force_ones` to 1 from the following cycle. `o_rai_abit` stays 0.
- R5: With only `i_en_rai` set, a trigger at a frame strobe drives `o_rai_abit` to 1. This bit is the A bit, bit 3 of the non-alignment timeslot 0 word. `o_force_ones` stays 0 in this mode.
- R6: The alarm outputs change only on a clock edge where `i_frame_strobe` is 1. Between strobes they hold.
- R7: The alarm outputs return to 0 at the first frame strobe at which the trigger is absent and no timeout applies.
- R8: In remote-alarm mode, a timeout occurs after `TIMEOUT_TICKS` ticks counted while frame aligned without multiframe alignment. After a timeout, `o_rai_abit` is 1 at every frame strobe, even with no trigger.
- R9: Loss of frame alignment clears the search count and any timeout.
- R10: Gaining multiframe alignment clears the count and any timeout. After it, the constant remote alarm ends at the next frame strobe.
- R11: In all-ones mode a timeout has no effect on either output.
- R12: After reset all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_frame_sync_lost | input | 1 | Receive frame alignment lost |
| i_ais_rx | input | 1 | All-ones alarm being received |
| i_sig_lost | input | 1 | Receive signal or carrier lost |
| i_mf_sync | input | 1 | CRC-4 multiframe alignment held |
| i_en_ais | input | 1 | Enable all-ones response |
| i_en_rai | input | 1 | Enable remote-alarm response |
| i_ms_tick | input | 1 | One-cycle pulse per millisecond |
| i_frame_strobe | input | 1 | One-cycle pulse at each transmit frame boundary |
| o_force_ones | output | 1 | Force transmit data to all ones |
| o_rai_abit | output | 1 | Remote alarm bit for the transmit framer |
| o_illegal_cfg | output | 1 | Both enables set |

## Verification
The assertions assume that `i_ms_tick` and `i_frame_strobe` are one-cycle pulses in step with `clk`. They also assume that the status flags are already synchronous and change only between edges. The bench drives every input at the falling edge and holds it for whole cycles. It changes multiframe alignment or frame alignment only while no tick is pending, and it waits two cycles after such a change before ticking. This keeps the counted number of ticks exact.

// File: rtl/e1_alarm_pkg.sv
package e1_alarm_pkg;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_AIS,
        MODE_RAI,
        MODE_BAD
    } alarm_mode_e;

    typedef enum logic [1:0] {
        TS_IDLE,
        TS_HUNT,
        TS_EXPIRED,
        TS_LOCKED
    } srch_state_e;

    typedef enum logic [1:0] {
        OS_QUIET,
        OS_SEND_AIS,
        OS_SEND_RAI
    } out_state_e;

endpackage

// File: rtl/e1_alarm_mode_dec.sv
module e1_alarm_mode_dec
    import e1_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_ais,
    input  logic        en_rai,
    output alarm_mode_e mode,
    output logic        illegal_q
);

    // R1, R2: two enable bits select one of four modes
    always_comb begin
        unique case ({en_rai, en_ais})
            2'b00:   mode = MODE_OFF;
            2'b01:   mode = MODE_AIS;
            2'b10:   mode = MODE_RAI;
            default: mode = MODE_BAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= (mode == MODE_BAD);
    end

endmodule

// File: rtl/e1_mfa_search_timer.sv
module e1_mfa_search_timer
    import e1_alarm_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_lost,
    input  logic mf_sync,
    input  logic tick,
    output logic expired
);

    localparam int              CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    srch_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (frame_lost) begin
            state_d = TS_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TS_IDLE: begin
                    cnt_d   = '0;
                    state_d = mf_sync ? TS_LOCKED : TS_HUNT;
                end
                TS_HUNT: begin
                    if (mf_sync) begin
                        state_d = TS_LOCKED;
                        cnt_d   = '0;
                    end else if (tick) begin
                        if (cnt_q == LAST) begin
                            state_d = TS_EXPIRED;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                TS_EXPIRED: begin
                    if (mf_sync) state_d = TS_LOCKED;
                end
                TS_LOCKED: begin
                    if (!mf_sync) begin
                        state_d = TS_HUNT;
                        cnt_d   = '0;
                    end
                end
                default: state_d = TS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb expired = (state_q == TS_EXPIRED);

    p_lost_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_lost |=> !expired);

    p_mf_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mf_sync |=> !expired);

    p_expire_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(tick));

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(TIMEOUT_TICKS));

endmodule

// File: rtl/e1_alarm_out_fsm.sv
module e1_alarm_out_fsm
    import e1_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_strobe,
    input  alarm_mode_e mode,
    input  logic        trigger,
    input  logic        search_expired,
    output logic        force_ones,
    output logic        rai_abit
);

    out_state_e state_q, state_d;

    always_comb begin
        unique case (mode)
            MODE_AIS: state_d = trigger ? OS_SEND_AIS : OS_QUIET;
            MODE_RAI: state_d = (trigger || search_expired) ? OS_SEND_RAI : OS_QUIET;
            default:  state_d = OS_QUIET;
        endcase
    end

    // R6: state advances only at a frame boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            state_q <= OS_QUIET;
        else if (frame_strobe) state_q <= state_d;
    end

    always_comb begin
        force_ones = (state_q == OS_SEND_AIS);
        rai_abit   = (state_q == OS_SEND_RAI);
    end

    p_hold_between_frames_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> ($stable(force_ones) && $stable(rai_abit)));

    p_bad_mode_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && mode == MODE_BAD) |=> (!force_ones && !rai_abit));

    p_rai_mode_no_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && mode == MODE_RAI) |=> !force_ones);

    p_off_mode_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && mode == MODE_OFF) |=> (!force_ones && !rai_abit));

endmodule

// File: rtl/e1_tx_alarm_ctrl.sv
module e1_tx_alarm_ctrl
    import e1_alarm_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic i_frame_sync_lost,
    input  logic i_ais_rx,
    input  logic i_sig_lost,
    input  logic i_mf_sync,
    input  logic i_en_ais,
    input  logic i_en_rai,
    input  logic i_ms_tick,
    input  logic i_frame_strobe,
    output logic o_force_ones,
    output logic o_rai_abit,
    output logic o_illegal_cfg
);

    alarm_mode_e mode;
    logic        trigger;
    logic        expired;

    // R3: any of the three receive faults triggers the response
    always_comb trigger = i_frame_sync_lost | i_ais_rx | i_sig_lost;

    e1_alarm_mode_dec u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_ais    (i_en_ais),
        .en_rai    (i_en_rai),
        .mode      (mode),
        .illegal_q (o_illegal_cfg)
    );

    e1_mfa_search_timer #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_lost (i_frame_sync_lost),
        .mf_sync    (i_mf_sync),
        .tick       (i_ms_tick),
        .expired    (expired)
    );

    e1_alarm_out_fsm u_out (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_strobe   (i_frame_strobe),
        .mode           (mode),
        .trigger        (trigger),
        .search_expired (expired),
        .force_ones     (o_force_ones),
        .rai_abit       (o_rai_abit)
    );

    p_ais_mode_needs_trigger_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (i_frame_strobe && i_en_ais && !i_en_rai && !trigger) |=> (!o_force_ones && !o_rai_abit));

endmodule

// File: tb/e1_tx_alarm_ctrl_tb.sv
module e1_tx_alarm_ctrl_tb;

    localparam int CLK_PERIOD    = 10;
    localparam int TIMEOUT_TICKS = 400;

    logic clk = 1'b0;
    logic rst_n;
    logic lofs, ais_rx, los, mf_sync, en_ais, en_rai, tick, strobe;
    logic force_ones, rai_abit, illegal;

    typedef struct {
        bit    ais;
        bit    rai;
        string tag;
    } exp_t;

    exp_t  expq[$];
    int    checks   = 0;
    int    failures = 0;
    bit    done     = 1'b0;
    logic  strobe_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    e1_tx_alarm_ctrl #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .i_frame_sync_lost (lofs),
        .i_ais_rx          (ais_rx),
        .i_sig_lost        (los),
        .i_mf_sync         (mf_sync),
        .i_en_ais          (en_ais),
        .i_en_rai          (en_rai),
        .i_ms_tick         (tick),
        .i_frame_strobe    (strobe),
        .o_force_ones      (force_ones),
        .o_rai_abit        (rai_abit),
        .o_illegal_cfg     (illegal)
    );

    always @(posedge clk) strobe_seen <= strobe;

    // monitor: compare outputs one cycle after each frame strobe
    always @(negedge clk) begin
        if (rst_n && strobe_seen) begin
            checks++;
            if (expq.size() == 0) begin
                failures++;
                $display("FAIL scoreboard empty force=%0b rai=%0b expected an entry", force_ones, rai_abit);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (force_ones !== e.ais || rai_abit !== e.rai) begin
                    failures++;
                    $display("FAIL %s force=%0b rai=%0b expected force=%0b rai=%0b",
                             e.tag, force_ones, rai_abit, e.ais, e.rai);
                end
            end
        end
    end

    task automatic frame(input bit ais, input bit rai, input string tag);
        @(negedge clk);
        strobe = 1'b1;
        expq.push_back('{ais, rai, tag});
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; lofs = 0; ais_rx = 0; los = 0; mf_sync = 1;
        en_ais = 0; en_rai = 0; tick = 0; strobe = 0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R12: reset values
        chk("R12 force", force_ones, 1'b0);
        chk("R12 rai", rai_abit, 1'b0);
        chk("R12 illegal", illegal, 1'b0);

        // R1: no mode, fault present
        lofs = 1;
        frame(0, 0, "R1 off mode");

        // R3, R4: all-ones mode, each fault source
        en_ais = 1;
        frame(1, 0, "R4 lofs trigger");
        lofs = 0;
        idle(3);
        chk("R6 hold between frames", force_ones, 1'b1);
        frame(0, 0, "R7 clear on first clean frame");
        ais_rx = 1;
        frame(1, 0, "R3 ais_rx trigger");
        ais_rx = 0; los = 1;
        frame(1, 0, "R3 sig lost trigger");
        los = 0;
        frame(0, 0, "R7 clear after sig lost");

        // R5: remote-alarm mode
        en_ais = 0; en_rai = 1; los = 1;
        frame(0, 1, "R5 rai on trigger");
        los = 0;
        idle(2);
        chk("R6 rai held", rai_abit, 1'b1);
        frame(0, 0, "R7 rai clear");

        // R2: illegal configuration
        los = 1;
        frame(0, 1, "R5 rai before illegal");
        en_ais = 1;
        idle(1);
        chk("R2 illegal flag set", illegal, 1'b1);
        frame(0, 0, "R2 no alarm when illegal");
        en_ais = 0;
        idle(1);
        chk("R2 illegal flag clear", illegal, 1'b0);
        los = 0;
        frame(0, 0, "R7 clean frame");

        // R8: search timeout in remote-alarm mode
        mf_sync = 0;
        idle(2);
        ticks(TIMEOUT_TICKS - 1);
        idle(1);
        frame(0, 0, "R8 one tick short");
        ticks(1);
        idle(1);
        frame(0, 1, "R8 timeout rai");
        frame(0, 1, "R8 constant rai");

        // R11: all-ones mode ignores the timeout
        en_rai = 0; en_ais = 1;
        frame(0, 0, "R11 ais mode ignores timeout");
        en_ais = 0; en_rai = 1;
        frame(0, 1, "R8 timeout still held");

        // R10: multiframe alignment clears and restarts
        mf_sync = 1;
        idle(1);
        frame(0, 0, "R10 mf sync ends rai");
        mf_sync = 0;
        idle(2);
        ticks(300);
        mf_sync = 1;
        idle(2);
        mf_sync = 0;
        idle(2);
        ticks(300);
        idle(1);
        frame(0, 0, "R10 count restarted");
        ticks(100);
        idle(1);
        frame(0, 1, "R8 timeout after restart");

        // R9: frame alignment loss clears the count
        mf_sync = 1;
        idle(2);
        frame(0, 0, "R10 cleared again");
        mf_sync = 0;
        idle(2);
        ticks(300);
        lofs = 1;
        idle(1);
        lofs = 0;
        idle(2);
        ticks(300);
        idle(1);
        frame(0, 0, "R9 lofs restarts count");

        idle(3);
        chk("scoreboard drained", expq.size() == 0, 1'b1);
        finish_run();
    end

endmodule